// File: doc/BRIEF.md
# Serial Dimension-Swap Reorderer

This block reorders a continuous stream of samples, one word per clock, that arrives in frames of 2^IDX_W samples. Each sample's arrival position within its frame is a binary number. The block exchanges two of its bits, HI_DIM and LO_DIM, where HI_DIM is greater than LO_DIM. Samples whose two chosen bits are equal keep their place. Samples whose two chosen bits differ trade places with a partner that arrived exactly SPAN = 2^HI_DIM - 2^LO_DIM samples earlier or later.

The datapath holds only SPAN words. It is a shift line of that length and two 2:1 selectors that share one steering bit. A free-running position counter decodes that bit. Chaining several of these stages with different bit pairs builds bit-reversed or digit-reversed reordering for pipelined FFT outputs. Frames follow one another with no gap. Idle cycles, marked by a low input valid, freeze the whole block and leave the sample order intact.

Top module: `bitx_permuter`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, out_vld and out_sof are 0. The position count and fill count restart from zero, so the first valid input after reset is position 0 of a new frame.
- R2: The arrival position advances by one on every valid input and wraps from 2^IDX_W-1 to 0. The next frame starts with no idle cycle needed.
- R3: The delay is SPAN = 2^HI_DIM - 2^LO_DIM samples. out_vld is 0 for the first SPAN valid inputs after reset. After that, out_vld is 1 in exactly the cycles where in_vld is 1, so with an unbroken input the output valid is the input valid delayed by SPAN cycles.
- R4: The output at frame position p carries the input sample from position p of the same frame when bits HI_DIM and LO_DIM of p are equal.
- R5: When bits HI_DIM and LO_DIM of p differ, the output at frame position p carries the input sample from position p with those two bits exchanged.
- R6: out_sof is 1 exactly when out_vld is 1 and the output sample is at frame position 0.
- R7: A cycle with in_vld low changes no state and drives out_vld low. The sample order seen across valid cycles is the same as with no idle cycles.
- R8: Every frame in a back-to-back series is reordered by the same rule as the first frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample valid; advances the block |
| in_data | input | DATA_W | Input sample |
| out_vld | output | 1 | Output sample valid |
| out_data | output | DATA_W | Reordered output sample |
| out_sof | output | 1 | Output sample is at frame position 0 |

## Verification
The bench targets the point where the fill count reaches SPAN. A design that is off by one there emits a garbage word, or drops the first real sample. It also targets the swapped samples, whose partner is still in the shift line when they are needed. A wrong steering decode, or a missing recirculation path, passes the equal-bit samples correctly but corrupts exactly half of each frame. Irregular idle gaps check that nothing shifts while in_vld is low; a design that shifted every cycle would scramble the order after the first gap. A mid-stream reset checks that the frame origin realigns, and a stale position count would show up as a misplaced out_sof.

// File: rtl/bitx_pkg.sv
package bitx_pkg;

  // Distance in samples between two swap partners.
  function automatic int unsigned swap_span(input int unsigned hi, input int unsigned lo);
    return (32'd1 << hi) - (32'd1 << lo);
  endfunction

  // Width of a counter able to hold the value v.
  function automatic int unsigned cnt_width(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/bitx_arrival_ctr.sv
module bitx_arrival_ctr #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned SPAN  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] pos,
  output logic             primed,
  output logic             out_origin
);
  localparam int unsigned FILL_W = bitx_pkg::cnt_width(SPAN);
  localparam logic [FILL_W-1:0] FILL_TOP = FILL_W'(SPAN);
  localparam logic [IDX_W-1:0]  ORIGIN   = IDX_W'(SPAN);

  logic [IDX_W-1:0]  pos_q, pos_nxt;
  logic [FILL_W-1:0] fill_q, fill_nxt;

  always_comb begin
    pos_nxt  = pos_q;
    fill_nxt = fill_q;
    if (adv) begin
      pos_nxt = pos_q + 1'b1;
      if (fill_q != FILL_TOP) fill_nxt = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      fill_q <= '0;
    end else if (adv) begin
      pos_q  <= pos_nxt;
      fill_q <= fill_nxt;
    end
  end

  assign pos        = pos_q;
  assign primed     = (fill_q == FILL_TOP);
  assign out_origin = (pos_q == ORIGIN);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && pos_q == {IDX_W{1'b1}}) |=> (pos_q == '0));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(pos_q) && $stable(fill_q)));
  p_primed_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);
endmodule

// File: rtl/bitx_delay_line.sv
module bitx_delay_line #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic [DATA_W-1:0] tail
);
  logic [DATA_W-1:0] stg_q   [DEPTH];
  logic [DATA_W-1:0] stg_nxt [DEPTH];

  always_comb begin
    stg_nxt[0] = din;
    for (int i = 1; i < DEPTH; i++) stg_nxt[i] = stg_q[i-1];
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stg_q[g] <= '0;
        else if (en) stg_q[g] <= stg_nxt[g];
      end
    end
  endgenerate

  assign head = stg_q[0];
  assign tail = stg_q[DEPTH-1];

  p_line_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(tail));
endmodule

// File: rtl/bitx_swap_ctrl.sv
module bitx_swap_ctrl #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned HI_DIM = 3,
  parameter int unsigned LO_DIM = 0
) (
  input  logic [IDX_W-1:0]  pos,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] line_tail,
  output logic              pass_sel,
  output logic [DATA_W-1:0] line_din,
  output logic [DATA_W-1:0] out_data
);
  // pass_sel high: sample goes through the line; low: bypass and recirculate.
  always_comb begin
    pass_sel = ~pos[HI_DIM] | pos[LO_DIM];
    if (pass_sel) begin
      line_din = in_data;
      out_data = line_tail;
    end else begin
      line_din = line_tail;
      out_data = in_data;
    end
  end
endmodule

// File: rtl/bitx_permuter.sv
module bitx_permuter #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned HI_DIM = 3,
  parameter int unsigned LO_DIM = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof
);
  localparam int unsigned SPAN = bitx_pkg::swap_span(HI_DIM, LO_DIM);

  generate
    if (HI_DIM <= LO_DIM || HI_DIM >= IDX_W) begin : g_bad_dims
      $error("bitx_permuter: need IDX_W > HI_DIM > LO_DIM");
    end
  endgenerate

  logic [IDX_W-1:0]  pos;
  logic              primed, out_origin, pass_sel;
  logic [DATA_W-1:0] line_din, line_head, line_tail;

  bitx_arrival_ctr #(.IDX_W(IDX_W), .SPAN(SPAN)) u_ctr (
    .clk(clk), .rst_n(rst_n), .adv(in_vld),
    .pos(pos), .primed(primed), .out_origin(out_origin)
  );

  bitx_swap_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .HI_DIM(HI_DIM), .LO_DIM(LO_DIM)) u_sel (
    .pos(pos), .in_data(in_data), .line_tail(line_tail),
    .pass_sel(pass_sel), .line_din(line_din), .out_data(out_data)
  );

  bitx_delay_line #(.DATA_W(DATA_W), .DEPTH(SPAN)) u_line (
    .clk(clk), .rst_n(rst_n), .en(in_vld), .din(line_din),
    .head(line_head), .tail(line_tail)
  );

  assign out_vld = in_vld & primed;
  assign out_sof = out_vld & out_origin;

  p_recirc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !pass_sel) |=> (line_head == $past(line_tail)));
  p_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && pass_sel) |=> (line_head == $past(in_data)));
  p_sof_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_vld);
  p_sof_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof && in_vld) |=> !out_sof);
endmodule

// File: tb/bitx_permuter_tb_top.sv
module bitx_permuter_tb_top;
  localparam int DW = 16, NB = 4, HJ = 3, LK = 0;
  localparam int N = 1 << NB;
  localparam int SP = (1 << HJ) - (1 << LK);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_vld, out_sof;
  logic [DW-1:0] out_data;

  int checks = 0, failures = 0;
  int gi = 0, tot = 0;
  int mem [0:1023];
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitx_permuter #(.DATA_W(DW), .IDX_W(NB), .HI_DIM(HJ), .LO_DIM(LK)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .out_vld(out_vld), .out_data(out_data), .out_sof(out_sof)
  );

  function automatic int swp(input int p);
    int bj = (p >> HJ) & 1;
    int bk = (p >> LK) & 1;
    int q = p & ~((1 << HJ) | (1 << LK));
    return q | (bj << LK) | (bk << HJ);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v);
    @(posedge clk); #1;
    in_vld = v;
    if (v) begin
      in_data = DW'((tot * 37 + 5) & 16'hFFFF);
      mem[gi] = int'(in_data);
      tot++;
    end
    @(negedge clk);
    if (v && gi >= SP) begin
      int go = gi - SP;
      int f = go / N;
      int p = go % N;
      int sp = swp(p);
      string tg;
      chk("R3 out_vld", int'(out_vld), 1);
      tg = (sp == p) ? "R4" : "R5";
      if (f > 0) tg = {tg, " R8"};
      chk({tg, " data"}, int'(out_data), mem[f * N + sp]);
      chk((f > 0) ? "R6 R2 sof" : "R6 sof", int'(out_sof), (p == 0) ? 1 : 0);
    end else begin
      chk(v ? "R3 out_vld fill" : "R7 out_vld idle", int'(out_vld), 0);
      chk(v ? "R6 sof fill" : "R7 sof idle", int'(out_sof), 0);
    end
    if (v) gi++;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; in_vld = 1'b0;
    @(negedge clk);
    chk("R1 out_vld in reset", int'(out_vld), 0);
    chk("R1 sof in reset", int'(out_sof), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    gi = 0;
  endtask

  initial begin
    do_reset();
    // unbroken stream, three frames
    for (int c = 0; c < 3 * N; c++) cyc(1'b1);
    // irregular idle gaps
    for (int c = 0; c < 6 * N; c++) cyc(((c * 7 + 3) % 5) != 0);
    // reset mid-stream, then realign
    do_reset();
    for (int c = 0; c < 2 * N + 3; c++) cyc(1'b1);
    cyc(1'b0);
    for (int c = 0; c < N; c++) cyc(1'b1);
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule